// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers nine external interrupt lines and keeps, for each line, a pending flag and a record of whether its handler is running. The highest-priority pending line that is enabled is offered to a processor core as a request bit and an exception number. The core answers with a one-cycle acknowledge when it enters the offered handler and a one-cycle completion pulse when it leaves the innermost running handler.

A request is captured only on a rising edge of a line. Any further edges that arrive before the handler is entered, or while it runs, collapse into one pending request. A line that is still high at the moment its handler completes is captured again, so a level source keeps being serviced while it stays asserted, and a pulse source is serviced once per burst. Handlers may nest: a request preempts the running handler only if its priority is strictly more urgent. A small stack holds the line index and the entry priority of each running handler, and each completion restores the previous running priority.

All inputs are synchronous to `clk`. Priorities, enables and software set and clear of pending flags are written through simple write ports.

Top module: `irqc_top`

## Requirements
- R1: After reset no line is pending, no handler is running, all enables are off and all priorities are 0; `req` is 0 and `exc_num` is 0.
- R2: A rising edge on `irq_line[i]` (high now, low in the previous cycle) sets pending for line i on that clock edge, whether or not the line is enabled. A line that stays high makes no new edge.
- R3: When `ack` is high while `req` is high, the offered line's pending flag is cleared and the line becomes the innermost running handler. When `ack` is high while `req` is low, nothing changes.
- R4: Any number of rising edges on a line between two handler entries give exactly one pending request, serviced once after the running handler completes.
- R5: On a `done` pulse while a handler runs, the innermost handler is removed; if its line is high in that cycle, the line becomes pending again.
- R6: Among pending, enabled lines the one with the smallest priority value wins, ties going to the lower line index; `exc_num` is 16 plus the winner's index (16 to 24) while `req` is high, and 0 while `req` is low.
- R7: `req` is high only when the winning priority is strictly smaller than the running priority (the entry priority of the innermost handler, or 4 when none runs). The handler stack holds four entries, which strict nesting over four priority levels never exceeds.
- R8: A line whose enable bit is 0 never drives `req`, but its pending flag is still set and is offered once the enable bit is written to 1.
- R9: `pend_set[i]` sets and `pend_clr[i]` clears pending for line i; a set (software or edge) in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line | input | 9 | Interrupt lines, bit i is line i |
| prio_we | input | 1 | Write strobe for one line's priority |
| prio_idx | input | 4 | Line index for the priority write |
| prio_val | input | 2 | Priority value, 0 is most urgent |
| en_we | input | 1 | Write strobe for the enable mask |
| en_val | input | 9 | New enable mask, bit i enables line i |
| pend_set | input | 9 | Software pending set, one bit per line |
| pend_clr | input | 9 | Software pending clear, one bit per line |
| ack | input | 1 | Core enters the offered handler |
| done | input | 1 | Core leaves the innermost handler |
| req | output | 1 | Interrupt request to the core |
| exc_num | output | 5 | Exception number of the offered line |

## Verification
The bench targets edge merging: several pulses on a line during its handler must yield one extra service, so a design that counted edges would offer the line a second time and one that dropped edges while active would never offer it again. It holds a line high across completion to expose a missing re-arm, which would let a level source go silent, and it offers equal-priority requests during a handler to catch a non-strict preemption test that would nest on a tie. It also checks index tie-breaks, a masked line that must surface after enabling, and an acknowledge with no request that must neither clear a flag nor push the stack.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DEF_LINES    = 9;
  localparam int unsigned DEF_PRIO_W   = 2;
  localparam int unsigned DEF_DEPTH    = 4;
  localparam int unsigned DEF_EXC_BASE = 16;
  localparam int unsigned DEF_EXC_W    = 5;
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_mask,
  input  logic [N-1:0] rearm_mask,
  output logic [N-1:0] rise,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  assign rise = line & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= line;
      pend <= (pend & ~(sw_clr | ack_mask)) | rise | sw_set | rearm_mask;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> pend[i]); // R2
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int unsigned N      = 9,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                win_valid,
  output logic [IW-1:0]       win_idx,
  output logic [PRIO_W-1:0]   win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] <= win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned IW     = 4,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned DW    = $clog2(DEPTH + 1),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [IW-1:0]     push_idx,
  input  logic [PRIO_W-1:0] push_prio,
  output logic              busy,
  output logic [IW-1:0]     top_idx,
  output logic [PRIO_W:0]   run_prio
);
  localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;

  logic [IW-1:0]     st_idx  [DEPTH];
  logic [PRIO_W-1:0] st_prio [DEPTH];
  logic [DW-1:0]     depth;
  logic [DW-1:0]     topp;
  logic              pop_ok;
  logic              full;

  assign busy   = (depth != '0);
  assign full   = (depth == DW'(DEPTH));
  assign topp   = depth - 1'b1;
  assign pop_ok = pop && busy;

  assign top_idx  = busy ? st_idx[AW'(topp)] : '0;
  assign run_prio = busy ? {1'b0, st_prio[AW'(topp)]} : IDLE_PRIO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_idx[i]  <= '0;
        st_prio[i] <= '0;
      end
    end else if (push && pop_ok) begin
      st_idx[AW'(topp)]  <= push_idx;
      st_prio[AW'(topp)] <= push_prio;
    end else if (push && !full) begin
      st_idx[AW'(depth)]  <= push_idx;
      st_prio[AW'(depth)] <= push_prio;
      depth <= depth + 1'b1;
    end else if (pop_ok) begin
      depth <= topp;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_ok) |-> !full); // R7
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_LINES  = DEF_LINES,
  parameter int unsigned PRIO_W   = DEF_PRIO_W,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned EXC_BASE = DEF_EXC_BASE,
  parameter int unsigned EXC_W    = DEF_EXC_W,
  localparam int unsigned IW      = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_line,
  input  logic               prio_we,
  input  logic [IW-1:0]      prio_idx,
  input  logic [PRIO_W-1:0]  prio_val,
  input  logic               en_we,
  input  logic [N_LINES-1:0] en_val,
  input  logic [N_LINES-1:0] pend_set,
  input  logic [N_LINES-1:0] pend_clr,
  input  logic               ack,
  input  logic               done,
  output logic               req,
  output logic [EXC_W-1:0]   exc_num
);
  function automatic logic [N_LINES-1:0] line_bit(input logic [IW-1:0] idx);
    return {{(N_LINES-1){1'b0}}, 1'b1} << idx;
  endfunction

  function automatic logic [EXC_W-1:0] exc_of(input logic [IW-1:0] idx);
    return EXC_W'(EXC_BASE) + EXC_W'(idx);
  endfunction

  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic [N_LINES-1:0]        en;
  logic [N_LINES-1:0]        pend;
  logic [N_LINES-1:0]        rise;
  logic [N_LINES-1:0]        ack_mask;
  logic [N_LINES-1:0]        rearm_mask;
  logic                      win_valid;
  logic [IW-1:0]             win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic                      busy;
  logic [IW-1:0]             top_idx;
  logic [PRIO_W:0]           run_prio;
  logic                      accept;
  logic                      finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_flat <= '0;
      en        <= '0;
    end else begin
      if (prio_we && (prio_idx < IW'(N_LINES)))
        prio_flat[prio_idx*PRIO_W +: PRIO_W] <= prio_val;
      if (en_we)
        en <= en_val;
    end
  end

  assign req     = win_valid && ({1'b0, win_prio} < run_prio);
  assign exc_num = req ? exc_of(win_idx) : '0;

  assign accept     = ack && req;
  assign finish     = done && busy;
  assign ack_mask   = accept ? line_bit(win_idx) : '0;
  assign rearm_mask = (finish && irq_line[top_idx]) ? line_bit(top_idx) : '0;

  irqc_pend #(.N(N_LINES)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .line       (irq_line),
    .sw_set     (pend_set),
    .sw_clr     (pend_clr),
    .ack_mask   (ack_mask),
    .rearm_mask (rearm_mask),
    .rise       (rise),
    .pend       (pend)
  );

  irqc_arb #(.N(N_LINES), .PRIO_W(PRIO_W)) u_arb (
    .cand      (pend & en),
    .prio_flat (prio_flat),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  irqc_stack #(.DEPTH(DEPTH), .IW(IW), .PRIO_W(PRIO_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .pop       (done),
    .push_idx  (win_idx),
    .push_prio (win_prio),
    .busy      (busy),
    .top_idx   (top_idx),
    .run_prio  (run_prio)
  );

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rise[win_idx] && !pend_set[win_idx] && !rearm_mask[win_idx])
      |=> !pend[$past(win_idx)]); // R3

  AST_REARM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && irq_line[top_idx]) |=> pend[$past(top_idx)]); // R5

  AST_EXC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (exc_num >= EXC_W'(EXC_BASE)) && (exc_num < EXC_W'(EXC_BASE + N_LINES))); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (exc_num == '0)); // R6
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] irq_line = '0;
  logic       prio_we = 1'b0;
  logic [3:0] prio_idx = '0;
  logic [1:0] prio_val = '0;
  logic       en_we = 1'b0;
  logic [8:0] en_val = '0;
  logic [8:0] pend_set = '0;
  logic [8:0] pend_clr = '0;
  logic       ack = 1'b0;
  logic       done = 1'b0;
  logic       req;
  logic [4:0] exc_num;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  string      q_tag[$];
  logic       q_req[$];
  logic [4:0] q_num[$];

  always #10 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
    .en_we(en_we), .en_val(en_val), .pend_set(pend_set), .pend_clr(pend_clr),
    .ack(ack), .done(done), .req(req), .exc_num(exc_num)
  );

  function automatic logic [4:0] num_of(input int line);
    return 5'(16 + line);
  endfunction

  task automatic expect_out(input string tag, input logic r, input int line);
    q_tag.push_back(tag);
    q_req.push_back(r);
    q_num.push_back(r ? num_of(line) : 5'd0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q_tag.size() > 0) begin
        string      t;
        logic       er;
        logic [4:0] en_;
        t   = q_tag.pop_front();
        er  = q_req.pop_front();
        en_ = q_num.pop_front();
        n_run++;
        if (req !== er || exc_num !== en_) begin
          n_fail++;
          $display("FAIL %s: req=%0b exc_num=%0d expected req=%0b exc_num=%0d",
                   t, req, exc_num, er, en_);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_prio(input int i, input int p);
    prio_we = 1'b1; prio_idx = 4'(i); prio_val = 2'(p);
    cyc();
    prio_we = 1'b0;
  endtask

  task automatic wr_en(input logic [8:0] m);
    en_we = 1'b1; en_val = m;
    cyc();
    en_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; cyc(); done = 1'b0;
  endtask

  task automatic edge_on(input int i);
    irq_line[i] = 1'b1; cyc(); irq_line[i] = 1'b0; cyc();
  endtask

  task automatic sw_set(input logic [8:0] m);
    pend_set = m; cyc(); pend_set = '0;
  endtask

  task automatic sw_clr(input logic [8:0] m);
    pend_clr = m; cyc(); pend_clr = '0;
  endtask

  initial begin : driver
    repeat (3) cyc();
    expect_out("R1 in reset", 1'b0, 0);
    rst_n = 1'b1;
    cyc();
    expect_out("R1 after reset", 1'b0, 0);

    wr_prio(0, 2); wr_prio(1, 3); wr_prio(2, 3); wr_prio(3, 1); wr_prio(4, 3);
    wr_prio(5, 1); wr_prio(6, 3); wr_prio(7, 3); wr_prio(8, 0);
    wr_en(9'h1FF);
    expect_out("R1 nothing pending", 1'b0, 0);

    edge_on(3);
    expect_out("R2 edge on line 3", 1'b1, 3);
    edge_on(5);
    expect_out("R6 tie goes to lower index", 1'b1, 3);
    pulse_ack();
    expect_out("R7 equal priority does not preempt", 1'b0, 0);
    edge_on(3);
    edge_on(3);
    expect_out("R4 edges during own handler held back", 1'b0, 0);

    irq_line[8] = 1'b1;
    cyc();
    expect_out("R7 more urgent line preempts", 1'b1, 8);
    pulse_ack();
    expect_out("R3 ack clears and nests", 1'b0, 0);
    pulse_done();
    expect_out("R5 high line re-pends at done", 1'b1, 8);
    pulse_ack();
    expect_out("R3 second entry of line 8", 1'b0, 0);
    irq_line[8] = 1'b0;
    pulse_done();
    expect_out("R5 low line not re-pended", 1'b0, 0);

    pulse_done();
    expect_out("R4 merged request after outer done", 1'b1, 3);
    pulse_ack();
    expect_out("R3 line 3 entered again", 1'b0, 0);
    pulse_done();
    expect_out("R4 only one merged service, then line 5", 1'b1, 5);
    pulse_ack();
    pulse_done();
    expect_out("R4 no extra service", 1'b0, 0);

    wr_en(9'h1FE);
    edge_on(0);
    expect_out("R8 masked line gives no request", 1'b0, 0);
    wr_en(9'h1FF);
    expect_out("R8 pending kept while masked", 1'b1, 0);

    sw_clr(9'h001);
    expect_out("R9 software clear", 1'b0, 0);
    sw_set(9'h004);
    expect_out("R9 software set", 1'b1, 2);
    pend_set = 9'h004; pend_clr = 9'h004;
    cyc();
    pend_set = '0; pend_clr = '0;
    expect_out("R9 set wins over clear", 1'b1, 2);
    sw_clr(9'h004);
    expect_out("R9 clear line 2", 1'b0, 0);

    wr_en(9'h1FD);
    sw_set(9'h002);
    pulse_ack();
    wr_en(9'h1FF);
    expect_out("R3 ack without request ignored", 1'b1, 1);
    pulse_ack();
    expect_out("R3 line 1 entered", 1'b0, 0);
    pulse_done();
    expect_out("R3 line 1 done", 1'b0, 0);

    irq_line[6] = 1'b1; irq_line[8] = 1'b1;
    cyc();
    irq_line[6] = 1'b0; irq_line[8] = 1'b0;
    expect_out("R6 smaller value beats lower index", 1'b1, 8);
    pulse_ack();
    expect_out("R7 line 6 cannot preempt line 8", 1'b0, 0);
    pulse_done();
    expect_out("R6 line 6 after line 8", 1'b1, 6);
    pulse_ack();
    pulse_done();
    expect_out("R1 idle at end", 1'b0, 0);

    cyc();
    cyc();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected end of sequence");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule